// File: doc/BRIEF.md
# Non-Preemptive Priority Bus Arbiter

This block decides which of several bus masters may use a single shared bus. Every master drives its own request line and receives its own grant line. While the bus is free, the arbiter picks one requester and raises that master's grant. The grant then stays with that master, whatever other requests appear, until the owner lowers its own request.

After a release the arbiter leaves every grant low for one clock. It then picks the next owner from the requests pending at that moment. The winner is chosen either by fixed priority, where the lowest index wins, or by a rotating search, selected by a mode input. The order in which requests arrived never matters.

Top module: `busArbiter`

## Requirements
- R1: While reset is asserted, and after it is released, every grant line is low until a request is arbitrated.
- R2: No more than one grant line is high in any cycle.
- R3: If no grant is active and at least one request is high at a clock edge, exactly one of those requesters is granted, visible right after that edge.
- R4: While the owner keeps its request high, its grant stays unchanged, even when other requests of any priority appear.
- R5: When the owner's request is low at a clock edge, all grants are low after that edge for exactly one cycle. At the next edge the pending requests are arbitrated.
- R6: With `rrMode` = 0, the requester with the lowest index (bit 0 highest) wins, regardless of which request arrived first.
- R7: With `rrMode` = 1, the search starts at the index after the last owner and wraps from NUM_MASTERS-1 to 0. The last-owner index is NUM_MASTERS-1 after reset and is updated on every grant in both modes.
- R8: If no request is high while the bus is free, no grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rrMode | input | 1 | 0 selects fixed priority, 1 selects the rotating search |
| busReq | input | NUM_MASTERS | Request line of each master |
| busGrant | output | NUM_MASTERS | One-hot grant lines, all low when the bus is free |

## Verification
A corrupted control state shows up at the ports within one clock. It appears either as a grant that survives its owner's release, or as a grant that moves directly from one master to another without the idle cycle. A wrong last-owner index is invisible in fixed-priority mode. In rotating mode it appears at the next arbitration that follows the index, as a grant to the wrong master. The table covers both modes and the wrap-around of the rotating search, so such a fault is caught in the first arbitration it affects.

// File: rtl/arbPkg.sv
package arbPkg;
  typedef enum logic {
    ST_FREE = 1'b0,
    ST_HELD = 1'b1
  } arbState_t;

  typedef struct packed {
    logic loadGrant;
    logic clearGrant;
  } arbStrobes_t;
endpackage

// File: rtl/arbDatapath.sv
module arbDatapath
  import arbPkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rrMode,
  input  logic [NUM_MASTERS-1:0] busReq,
  input  arbStrobes_t            strobes,
  output logic [NUM_MASTERS-1:0] grantQ,
  output logic                   anyReq,
  output logic                   ownerReq
);
  localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
  localparam logic [IDX_W:0] LAST_IDX = IDX_W'(NUM_MASTERS - 1);
  localparam logic [IDX_W:0] COUNT = (IDX_W + 1)'(NUM_MASTERS);

  logic [IDX_W-1:0]       lastOwner;
  logic [NUM_MASTERS-1:0] fixedWin;
  logic [NUM_MASTERS-1:0] rrWin;
  logic [NUM_MASTERS-1:0] winner;
  logic [IDX_W-1:0]       winnerIdx;

  assign anyReq   = |busReq;
  assign ownerReq = |(busReq & grantQ);

  // Fixed priority: scan downward so the lowest set index is assigned last
  always_comb begin
    fixedWin = '0;
    for (int i = NUM_MASTERS - 1; i >= 0; i--) begin
      if (busReq[i]) begin
        fixedWin    = '0;
        fixedWin[i] = 1'b1;
      end
    end
  end

  // Rotating search from lastOwner+1, wrapping
  always_comb begin
    logic [IDX_W:0] probe;
    logic           found;
    rrWin = '0;
    found = 1'b0;
    for (int off = 1; off <= NUM_MASTERS; off++) begin
      probe = {1'b0, lastOwner} + (IDX_W + 1)'(off);
      if (probe >= COUNT) probe = probe - COUNT;
      if (!found && busReq[probe[IDX_W-1:0]]) begin
        rrWin[probe[IDX_W-1:0]] = 1'b1;
        found = 1'b1;
      end
    end
  end

  assign winner = rrMode ? rrWin : fixedWin;

  always_comb begin
    winnerIdx = '0;
    for (int i = 0; i < NUM_MASTERS; i++) begin
      if (winner[i]) winnerIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantQ    <= '0;
      lastOwner <= LAST_IDX[IDX_W-1:0];
    end else if (strobes.loadGrant) begin
      grantQ    <= winner;
      lastOwner <= winnerIdx;
    end else if (strobes.clearGrant) begin
      grantQ <= '0;
    end
  end
endmodule

// File: rtl/arbControl.sv
module arbControl
  import arbPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyReq,
  input  logic        ownerReq,
  output arbStrobes_t strobes
);
  arbState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_FREE: if (anyReq) begin
        strobes.loadGrant = 1'b1;
        stateNext         = ST_HELD;
      end
      ST_HELD: if (!ownerReq) begin
        strobes.clearGrant = 1'b1;
        stateNext          = ST_FREE;
      end
      default: stateNext = ST_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FREE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/busArbiter.sv
module busArbiter
  import arbPkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rrMode,
  input  logic [NUM_MASTERS-1:0] busReq,
  output logic [NUM_MASTERS-1:0] busGrant
);
  arbStrobes_t strobes;
  logic        anyReq;
  logic        ownerReq;

  arbControl ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .anyReq   (anyReq),
    .ownerReq (ownerReq),
    .strobes  (strobes)
  );

  arbDatapath #(.NUM_MASTERS(NUM_MASTERS)) dp (
    .clk      (clk),
    .rstN     (rstN),
    .rrMode   (rrMode),
    .busReq   (busReq),
    .strobes  (strobes),
    .grantQ   (busGrant),
    .anyReq   (anyReq),
    .ownerReq (ownerReq)
  );
endmodule

// File: rtl/busArbiterChecker.sv
module busArbiterChecker #(
  parameter int NUM_MASTERS = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   rrMode,
  input logic [NUM_MASTERS-1:0] busReq,
  input logic [NUM_MASTERS-1:0] busGrant
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rstN |=> busGrant == '0);

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busGrant));

  // R3
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busGrant == '0 && busReq != '0) |=> (busGrant & $past(busReq)) != '0);

  // R4
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((busGrant & busReq) != '0) |=> busGrant == $past(busGrant));

  // R5
  release_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busGrant != '0 && (busGrant & busReq) == '0) |=> busGrant == '0);

  // R6
  fixed_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rrMode && busGrant == '0 && busReq != '0)
      |=> busGrant == ($past(busReq) & (~$past(busReq) + 1'b1)));

  // R8
  no_req_no_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busGrant == '0 && busReq == '0) |=> busGrant == '0);
endmodule

bind busArbiter busArbiterChecker #(.NUM_MASTERS(NUM_MASTERS)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .rrMode   (rrMode),
  .busReq   (busReq),
  .busGrant (busGrant)
);

// File: tb/busArbiter_test.sv
module busArbiter_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         rrMode = 1'b0;
  logic [N-1:0] busReq = '0;
  logic [N-1:0] busGrant;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  busArbiter #(.NUM_MASTERS(N)) uut (
    .clk      (clk),
    .rstN     (rstN),
    .rrMode   (rrMode),
    .busReq   (busReq),
    .busGrant (busGrant)
  );

  // {rrMode, busReq[3:0], expected busGrant[3:0]}; bit 0 = highest priority
  localparam int NV = 21;
  localparam logic [8:0] VEC [NV] = '{
    {1'b0, 4'b0100, 4'b0100},  // R3 single request granted
    {1'b0, 4'b0101, 4'b0100},  // R4 higher priority does not preempt
    {1'b0, 4'b1101, 4'b0100},  // R4
    {1'b0, 4'b1001, 4'b0000},  // R5 release gap
    {1'b0, 4'b1001, 4'b0001},  // R6 index 0 beats earlier index 3
    {1'b0, 4'b1000, 4'b0000},  // R5
    {1'b0, 4'b1000, 4'b1000},  // R3
    {1'b0, 4'b0000, 4'b0000},  // R5
    {1'b0, 4'b0000, 4'b0000},  // R8 idle, no grant
    {1'b1, 4'b0110, 4'b0010},  // R7 last=3, search from 0
    {1'b1, 4'b0100, 4'b0000},  // R5
    {1'b1, 4'b0111, 4'b0100},  // R7 after 1 comes 2
    {1'b1, 4'b0011, 4'b0000},  // R5
    {1'b1, 4'b0011, 4'b0001},  // R7 wrap 3 -> 0
    {1'b1, 4'b0010, 4'b0000},  // R5
    {1'b1, 4'b1010, 4'b0010},  // R7
    {1'b1, 4'b1000, 4'b0000},  // R5
    {1'b1, 4'b1001, 4'b1000},  // R7 after 1: 2 idle, 3 wins
    {1'b0, 4'b0001, 4'b0000},  // R5
    {1'b0, 4'b0110, 4'b0010},  // R6 fixed again
    {1'b0, 4'b0000, 4'b0000}   // R5
  };

  task automatic check(input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: busGrant=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset asserted", busGrant, '0);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", busGrant, '0);

    for (int i = 0; i < NV; i++) begin
      rrMode = VEC[i][8];
      busReq = VEC[i][7:4];
      @(posedge clk); #1;
      check($sformatf("vector %0d", i), busGrant, VEC[i][3:0]);
      if (!$onehot0(busGrant)) check("R2 one-hot", busGrant, '0);
    end

    // R1: reset while a grant is held
    rrMode = 1'b0;
    busReq = 4'b0010;
    @(posedge clk); #1;
    check("R3 grant before reset", busGrant, 4'b0010);
    rstN = 1'b0;
    #1;
    check("R1 reset clears held grant", busGrant, '0);
    @(posedge clk); #1;
    rstN = 1'b1;
    busReq = 4'b1010;
    // R7: last owner restored to 3, so rotating search starts at 0 -> master 1
    rrMode = 1'b1;
    @(posedge clk); #1;
    check("R7 rotation restarts after reset", busGrant, 4'b0010);
    // R4: held across many cycles
    busReq = 4'b1111;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #1;
      check("R4 long hold", busGrant, 4'b0010);
    end
    busReq = '0;
    @(posedge clk); #1;
    check("R5 drop clears", busGrant, '0);
    @(posedge clk); #1;
    check("R8 nothing pending", busGrant, '0);

    finishRun();
  end
endmodule